// File: doc/BRIEF.md
# Flag-Setting 16-Bit Arithmetic-Logic Unit

This block is the arithmetic and logic stage of a small 16-bit processor datapath. Two operands arrive from the operand registers, a 3-bit operation selector picks one of eight functions, and the 16-bit result is produced combinationally so that the surrounding datapath can latch it into its output register in the same cycle.

A per-instruction invert control complements the second operand before any function sees it. Paired with the add function, this control also forces a carry-in of one, so one adder serves for addition, subtraction and compare. A separate per-instruction flag-enable control decides whether the four status flags (overflow, carry, zero, negative) are captured on the next rising clock edge. When it is low, the flags keep their old values, so a later conditional instruction can test a compare that was made earlier. The flag outputs go to a condition evaluator outside this block.

Top module: `flag_alu`

## Requirements
- R1: The operation selector `op_sel` is encoded as 0 add, 1 and, 2 or, 3 xor, 4 not, 5 shift left, 6 logical shift right and 7 arithmetic shift right. Add returns (A + Beff + inv_b) mod 2^16, where Beff is the effective second operand.
- R2: Beff equals ~B when `inv_b` is 1 and B otherwise. It feeds and, or, xor, the shift amount and the adder. Add with `inv_b`=1 therefore gives A - B.
- R3: The not function returns ~A and ignores B.
- R4: The two logical shifts move A by Beff bit positions and fill with zeros. A shift amount of 16 or more gives 0.
- R5: The arithmetic right shift fills with copies of A[15]. A shift amount of 16 or more gives 16 copies of A[15].
- R6: The overflow flag is set for add when A[15] equals Beff[15] and result[15] differs from A[15]. It is 0 for every other function.
- R7: For add, the carry flag is the carry out of bit 15. For and, or, xor and not it is 0.
- R8: For shifts, the carry flag is the last bit moved out: A[16-n] for a left shift by n, and A[n-1] for a right shift, for n from 1 to 15. It is 0 for n = 0. For n of 16 or more it is 0 for the logical shifts and A[15] for the arithmetic shift.
- R9: The zero flag is set when the 16-bit result is zero. The negative flag equals result bit 15.
- R10: The flags load on a rising clock edge only when `flag_en` is 1. Otherwise they hold their value. The result does not depend on `flag_en`.
- R11: A rising edge with `rst_n` low clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand, or shift amount |
| op_sel | input | 3 | Function selector |
| inv_b | input | 1 | Complement the second operand; carry-in of one on add |
| flag_en | input | 1 | Capture the flags on this edge |
| result | output | 16 | Combinational function result |
| flag_v | output | 1 | Registered signed overflow |
| flag_c | output | 1 | Registered carry / shifted-out bit |
| flag_z | output | 1 | Registered zero |
| flag_s | output | 1 | Registered negative |

## Verification
The hardest behaviour to reach from the ports is the shift carry at the edges of the amount range: amounts 0, 15, 16 and 17, and amounts far above the width. In that range the logical and arithmetic shifts disagree on the carry. Directed vectors hit each of these amounts. They also use the invert control to turn a small second operand into a huge amount (zero inverted gives 65535) or into a small one (0xFFFE inverted gives 1). Hold behaviour is tested by sending a zero-producing vector with the flag enable low straight after vectors that set the flags. A seeded stream of mixed vectors follows and is checked against an independent bit-by-bit model.

// File: rtl/flag_alu_pkg.sv
// Package: shared width, function encoding and flag bundle for the ALU.
// Assumes: the selector encoding is fixed, because the decoder drives it directly.
package flag_alu_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_NOT = 3'd4,
        OP_LSL = 3'd5,
        OP_LSR = 3'd6,
        OP_ASR = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic ovf;
        logic cry;
        logic zero;
        logic neg;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Module: ripple-free adder used for add, subtract and compare.
// Assumes: the caller has already complemented b when it wants a subtract,
// and drives cin to 1 in that case.
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W:0] wide_sum;

    // Full-width sum with one extra bit for the carry out.
    always_comb begin
        wide_sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end

    assign sum  = wide_sum[W-1:0];
    assign cout = wide_sum[W];

    // Signed overflow: operands agree in sign, and the sum sign differs from them.
    always_comb begin
        ovf = (a[W-1] == b[W-1]) && (wide_sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise functions (and, or, xor, not).
// Assumes: b is the effective operand (already inverted when requested).
// Selector values outside the bitwise group give zero.
module alu_logic_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    input  flag_alu_pkg::alu_op_e  op,
    output logic [W-1:0]           res
);

    import flag_alu_pkg::*;

    // Pick the bitwise function for the selected operation.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_shift_unit.sv
// Module: barrel shifter for left, logical right and arithmetic right shifts,
// with the last bit shifted out reported as a carry.
// Assumes: amt is the full effective second operand. Any amount of W or more
// saturates.
module alu_shift_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           amt,
    input  flag_alu_pkg::alu_op_e  op,
    output logic [W-1:0]           res,
    output logic                   cout
);

    import flag_alu_pkg::*;

    localparam int SHW = $clog2(W);

    logic [SHW-1:0]   amt_lo;
    logic             amt_over;
    logic [W:0]       ext_l;
    logic [W:0]       ext_r;
    logic signed [W:0] ext_a;

    assign amt_lo = amt[SHW-1:0];

    // Any set bit above the in-range field means the amount is W or more.
    always_comb begin
        amt_over = |amt[W-1:SHW];
    end

    // Extend by one bit on the side the data leaves, so the guard bit holds the last bit out.
    always_comb begin
        ext_l = {1'b0, a} << amt_lo;
        ext_r = {a, 1'b0} >> amt_lo;
        ext_a = $signed({a, 1'b0}) >>> amt_lo;
    end

    // Select the shift flavour and apply saturation for oversized amounts.
    always_comb begin
        res  = '0;
        cout = 1'b0;
        case (op)
            OP_LSL: begin
                if (!amt_over) begin
                    res  = ext_l[W-1:0];
                    cout = ext_l[W];
                end
            end
            OP_LSR: begin
                if (!amt_over) begin
                    res  = ext_r[W:1];
                    cout = ext_r[0];
                end
            end
            OP_ASR: begin
                if (amt_over) begin
                    res  = {W{a[W-1]}};
                    cout = a[W-1];
                end else begin
                    res  = ext_a[W:1];
                    cout = ext_a[0];
                end
            end
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Module: four-bit status register with load enable.
// Assumes: synchronous active-low reset; the value holds when load is low.
module alu_flag_reg (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  flag_alu_pkg::alu_flags_t  d,
    output flag_alu_pkg::alu_flags_t  q
);

    // Clear on reset; otherwise capture new flags only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/flag_alu.sv
// Module: top of the flag-setting ALU. The result is combinational; the flags
// are registered under flag_en.
// Assumes: op_sel follows the package encoding. inv_b complements the second
// operand for every function and gives a carry-in of one on add.
module flag_alu #(
    parameter int W = flag_alu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   op_sel,
    input  logic         inv_b,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic         flag_v,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_s
);

    import flag_alu_pkg::*;

    alu_op_e    op;
    logic [W-1:0] b_eff;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] logic_res;
    logic [W-1:0] shift_res;
    logic         shift_cout;
    alu_flags_t   flags_next;
    alu_flags_t   flags_q;

    assign op = alu_op_e'(op_sel);

    // Effective second operand: complemented when requested.
    always_comb begin
        b_eff = inv_b ? ~opnd_b : opnd_b;
    end

    alu_addsub #(.W(W)) u_add (
        .a    (opnd_a),
        .b    (b_eff),
        .cin  (inv_b),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (b_eff),
        .op  (op),
        .res (logic_res)
    );

    alu_shift_unit #(.W(W)) u_shift (
        .a    (opnd_a),
        .amt  (b_eff),
        .op   (op),
        .res  (shift_res),
        .cout (shift_cout)
    );

    // Route the selected function unit to the result port.
    always_comb begin
        case (op)
            OP_ADD:                 result = add_sum;
            OP_LSL, OP_LSR, OP_ASR: result = shift_res;
            default:                result = logic_res;
        endcase
    end

    // Form the candidate flags from the selected unit and the result.
    always_comb begin
        flags_next.ovf  = (op == OP_ADD) ? add_ovf : 1'b0;
        case (op)
            OP_ADD:                 flags_next.cry = add_cout;
            OP_LSL, OP_LSR, OP_ASR: flags_next.cry = shift_cout;
            default:                flags_next.cry = 1'b0;
        endcase
        flags_next.zero = (result == '0);
        flags_next.neg  = result[W-1];
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_en),
        .d     (flags_next),
        .q     (flags_q)
    );

    assign flag_v = flags_q.ovf;
    assign flag_c = flags_q.cry;
    assign flag_z = flags_q.zero;
    assign flag_s = flags_q.neg;

endmodule

// File: rtl/flag_alu_chk.sv
// Module: property checker for flag_alu, attached by bind.
// Assumes: it only observes the top-level ports.
module flag_alu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   op_sel,
    input logic         inv_b,
    input logic         flag_en,
    input logic [W-1:0] result,
    input logic         flag_v,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_s
);

    logic rst_seen_q;

    // Remember that the last edge was taken in reset.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (rst_seen_q) begin
            assert_reset_clear_R11: assert ({flag_v, flag_c, flag_z, flag_s} == 4'b0000)
                else $error("flags not cleared by reset");
        end
    end

    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable({flag_v, flag_c, flag_z, flag_s}));

    assert_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (flag_z == ($past(result) == '0)));

    assert_sign_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_en |=> (flag_s == $past(result[W-1])));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_sel != 3'd0) |=> !flag_v);

    assert_logic_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_sel >= 3'd1 && op_sel <= 3'd4) |=> !flag_c);

    assert_not_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd4) |-> (result == ~opnd_a));

    assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd0 && inv_b) |-> (result == opnd_a - opnd_b));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_flag_alu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .op_sel  (op_sel),
    .inv_b   (inv_b),
    .flag_en (flag_en),
    .result  (result),
    .flag_v  (flag_v),
    .flag_c  (flag_c),
    .flag_z  (flag_z),
    .flag_s  (flag_s)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  op_sel = '0;
    logic        inv_b = 1'b0;
    logic        flag_en = 1'b0;
    logic [15:0] result;
    logic        flag_v, flag_c, flag_z, flag_s;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] res;
        logic [3:0]  flg;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [3:0] mflg = 4'b0000;   // model flags {v,c,z,s}

    always #10 clk = ~clk;        // 50 MHz

    flag_alu dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .inv_b(inv_b), .flag_en(flag_en), .result(result),
        .flag_v(flag_v), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
    );

    // Independent reference model, written bit-serially from the requirements.
    function automatic void ref_alu(input logic [15:0] a, input logic [15:0] b,
                                    input logic [2:0] op, input logic inv,
                                    output logic [15:0] r, output logic v, output logic c);
        logic [15:0] be;
        logic [16:0] s;
        int amt;
        int n;
        be = inv ? ~b : b;
        v = 1'b0;
        c = 1'b0;
        r = '0;
        amt = int'(be);
        n = (amt > 17) ? 17 : amt;
        case (op)
            3'd0: begin
                s = {1'b0, a} + {1'b0, be} + {16'd0, inv};
                r = s[15:0];
                c = s[16];
                v = (a[15] == be[15]) && (r[15] != a[15]);
            end
            3'd1: r = a & be;
            3'd2: r = a | be;
            3'd3: r = a ^ be;
            3'd4: r = ~a;
            3'd5: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[15]; r = r << 1; end
                if (amt >= 16) c = 1'b0;
            end
            3'd6: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[0]; r = r >> 1; end
                if (amt >= 16) c = 1'b0;
            end
            default: begin
                r = a;
                for (int i = 0; i < n; i++) begin c = r[0]; r = {r[15], r[15:1]}; end
            end
        endcase
    endfunction

    // Driver: apply one vector at the falling edge and queue what it should produce.
    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [2:0] op,
                         input logic inv, input logic en, input string tag);
        logic [15:0] r;
        logic v, c;
        exp_t e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; inv_b = inv; flag_en = en;
        ref_alu(a, b, op, inv, r, v, c);
        if (en) mflg = {v, c, (r == 16'd0), r[15]};
        e.res = r;
        e.flg = mflg;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: after each rising edge, compare the result and the newly settled flags.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_chk++;
                if (result !== e.res) begin
                    n_fail++;
                    $display("FAIL %s result: actual %h expected %h", e.tag, result, e.res);
                end
                n_chk++;
                if ({flag_v, flag_c, flag_z, flag_s} !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s flags vczs: actual %b expected %b", e.tag,
                             {flag_v, flag_c, flag_z, flag_s}, e.flg);
                end
            end
        end
    end

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: tag_of = "R1/R6/R7";
            3'd1, 3'd2, 3'd3: tag_of = "R2";
            3'd4: tag_of = "R3";
            3'd5, 3'd6: tag_of = "R4/R8";
            default: tag_of = "R5/R8";
        endcase
    endfunction

    // Stimulus sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;   // R11 reset state
        if ({flag_v, flag_c, flag_z, flag_s} !== 4'b0000) begin
            n_fail++;
            $display("FAIL R11 reset flags: actual %b expected 0000",
                     {flag_v, flag_c, flag_z, flag_s});
        end
        rst_n = 1'b1;

        drive(16'd3, 16'd4, 3'd0, 1'b0, 1'b1, "R1 add");
        drive(16'hFFFF, 16'd1, 3'd0, 1'b0, 1'b1, "R7 carry R9 zero");
        drive(16'h7FFF, 16'd1, 3'd0, 1'b0, 1'b1, "R6 overflow");
        drive(16'hF0F0, 16'hFF00, 3'd1, 1'b0, 1'b1, "R6 and clears V");
        drive(16'd5, 16'd5, 3'd0, 1'b1, 1'b1, "R2 sub equal");
        drive(16'd3, 16'd5, 3'd0, 1'b1, 1'b1, "R2 sub negative");
        drive(16'h8000, 16'd1, 3'd0, 1'b1, 1'b1, "R6 sub overflow");
        drive(16'hF0F0, 16'h0F00, 3'd2, 1'b0, 1'b1, "R7 or");
        drive(16'hFFFF, 16'h00FF, 3'd1, 1'b1, 1'b1, "R2 and inverted");
        drive(16'hAAAA, 16'hFFFF, 3'd3, 1'b0, 1'b1, "R2 xor");
        drive(16'h1234, 16'h5A5A, 3'd4, 1'b0, 1'b1, "R3 not");
        drive(16'h1234, 16'h0000, 3'd4, 1'b1, 1'b1, "R3 not ignores B");
        drive(16'h8001, 16'd1, 3'd5, 1'b0, 1'b1, "R8 lsl carry");
        drive(16'h8001, 16'd0, 3'd5, 1'b0, 1'b1, "R8 lsl by 0");
        drive(16'h0001, 16'd15, 3'd5, 1'b0, 1'b1, "R4 lsl by 15");
        drive(16'hFFFF, 16'd16, 3'd5, 1'b0, 1'b1, "R4 lsl by 16");
        drive(16'h0003, 16'd1, 3'd6, 1'b0, 1'b1, "R8 lsr carry");
        drive(16'hFFFF, 16'd20, 3'd6, 1'b0, 1'b1, "R4 lsr by 20");
        drive(16'h0001, 16'hFFFE, 3'd5, 1'b1, 1'b1, "R2 inverted amount 1");
        drive(16'h8000, 16'd4, 3'd7, 1'b0, 1'b1, "R5 asr");
        drive(16'h8008, 16'd4, 3'd7, 1'b0, 1'b1, "R8 asr carry");
        drive(16'h8000, 16'd16, 3'd7, 1'b0, 1'b1, "R5 asr by 16");
        drive(16'h4000, 16'd17, 3'd7, 1'b0, 1'b1, "R5 asr positive by 17");
        drive(16'h8000, 16'h0000, 3'd7, 1'b1, 1'b1, "R5 asr inverted huge");
        drive(16'h7FFF, 16'd1, 3'd0, 1'b0, 1'b1, "R6 set before hold");
        drive(16'd5, 16'd5, 3'd0, 1'b1, 1'b0, "R10 hold on zero result");
        drive(16'h0000, 16'h0000, 3'd4, 1'b0, 1'b0, "R10 hold again");

        for (int k = 0; k < 300; k++) begin
            logic [2:0]  op;
            logic [15:0] b;
            op = 3'($urandom_range(0, 7));
            b = 16'($urandom);
            if (op >= 3'd5 && ($urandom_range(0, 3) != 0)) b = 16'($urandom_range(0, 18));
            drive(16'($urandom), b, op, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), tag_of(op));
        end

        repeat (3) @(posedge clk);
        #6;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule